// File: doc/BRIEF.md
# Shared interrupt affinity router

This block owns the routing state of the shared (global) interrupts in an interrupt controller. Every shared interrupt has an 8-byte routing slot on a 32-bit register bus, and software writes a CPU affinity into it. The block turns the written affinity into a CPU index by comparing it against a small table of per-CPU affinities, supplied as an input. It keeps one bitmap per CPU that lists the shared interrupts routed to that CPU, and it keeps those bitmaps consistent with the slots.

An affinity that matches no CPU is still stored and reads back unchanged. The interrupt then belongs to no bitmap, and its target index holds a reserved code. Such an interrupt can still become pending elsewhere, but it is never delivered. Only three affinity levels are kept. They are packed into one 32-bit word per slot. The half of a slot that would carry the top level reads as zero.

Top module: `spi_affinity_router`

## Requirements
- R1: Slot s lives at byte offset 8*s. Its lower word (address bit 2 = 0) holds the affinity as level 0 in bits [7:0], level 1 in bits [15:8] and level 2 in bits [23:16]. Bits [31:24] read as zero whatever was written there.
- R2: The upper word of every slot (address bit 2 = 1) reads as zero. A write to it changes no slot, no target index and no bitmap.
- R3: A read returns the stored affinity levels exactly as last written (or as set at reset) on `reg_rdata`, in the cycle after `reg_rd` is sampled.
- R4: A lower-word write whose levels 0..2 equal CPU c's table entry does three things: it sets the slot's target index to c, it clears the slot's bit in the bitmap of the previously routed CPU, and it sets the bit in CPU c's bitmap. Each interrupt sits in at most one bitmap.
- R5: A lower-word write that matches no table entry sets the target index to 8'hFF and leaves the interrupt in no bitmap. The value is still stored and read back.
- R6: After reset every slot holds CPU 0's table affinity and every target index is 0. CPU 0's bitmap has all bits set and every other bitmap is empty.
- R7: Target and bitmap updates are visible in the cycle after the write is sampled. Only the written slot changes, and with no write nothing changes.
- R8: When several table entries hold the same affinity, the lowest CPU index is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one word per cycle |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte offset within the routing space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| cpu_aff_tab | input | NUM_CPU*24 | Per-CPU affinity, levels 0..2; CPU c at bits [24c+23:24c] |
| cpu_spi_map | output | NUM_CPU*NUM_SPI | Bitmap for CPU c at bits [c*NUM_SPI +: NUM_SPI], bit s for interrupt s |
| spi_target | output | NUM_SPI*8 | Target index for interrupt s at bits [8s+7:8s], 8'hFF when unrouted |

## Verification
Every result is due exactly one register stage after its stimulus. A write sampled at a rising edge has updated the target indices and bitmaps by the next edge, and read data appears one edge after `reg_rd`. The bench drives on falling edges and samples on the falling edge that follows the updating edge, so no check depends on evaluation order. After every write it compares all targets and all bitmaps against a bench model, and it reads back the written slot.

// File: rtl/spi_route_pkg.sv
package spi_route_pkg;
  localparam int TGT_W = 8;
  localparam logic [TGT_W-1:0] TGT_NONE = 8'hFF;
  localparam int AFF_W = 24;

  // Register word (lower half) -> stored packed word; level 3 slot kept zero
  function automatic logic [31:0] pack_aff(input logic [31:0] lo);
    return {8'h00, lo[23:16], lo[15:8], lo[7:0]};
  endfunction

  // Stored packed word -> 64-bit register layout (level 3 would sit at [39:32])
  function automatic logic [63:0] unpack_aff(input logic [31:0] c);
    return {24'h0, c[31:24], 8'h00, c[23:16], c[15:8], c[7:0]};
  endfunction
endpackage

// File: rtl/aff_lookup.sv
module aff_lookup
  import spi_route_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic [AFF_W-1:0]         aff,
  input  logic [NUM_CPU*AFF_W-1:0] tab,
  output logic                     hit,
  output logic [TGT_W-1:0]         idx
);
  always_comb begin
    hit = 1'b0;
    idx = TGT_NONE;
    for (int c = NUM_CPU - 1; c >= 0; c--) begin
      if (tab[c*AFF_W +: AFF_W] == aff) begin
        hit = 1'b1;
        idx = TGT_W'(c);
      end
    end
  end
endmodule

// File: rtl/spi_route_store.sv
module spi_route_store
  import spi_route_pkg::*;
#(
  parameter int NUM_SPI = 8,
  parameter int NUM_CPU = 4,
  localparam int SLOT_W = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_stb,
  input  logic [SLOT_W-1:0]          wr_slot,
  input  logic [31:0]                wr_aff,
  input  logic [TGT_W-1:0]           new_tgt,
  input  logic [AFF_W-1:0]           rst_aff,
  input  logic [SLOT_W-1:0]          rd_slot,
  output logic [31:0]                rd_aff,
  output logic [NUM_SPI*TGT_W-1:0]   tgt_flat,
  output logic [NUM_CPU*NUM_SPI-1:0] map_flat
);
  logic [31:0] aff_arr [NUM_SPI];

  for (genvar s = 0; s < NUM_SPI; s++) begin : g_spi
    logic [31:0]      aff_q;
    logic [TGT_W-1:0] tgt_q;
    logic             wr_me;
    assign wr_me = wr_stb && (wr_slot == SLOT_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        aff_q <= {8'h00, rst_aff};
        tgt_q <= '0;
      end else if (wr_me) begin
        aff_q <= wr_aff;
        tgt_q <= new_tgt;
      end
    end
    assign aff_arr[s] = aff_q;
    assign tgt_flat[s*TGT_W +: TGT_W] = tgt_q;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic bit_q;
      logic bit_d;
      always_comb begin
        bit_d = bit_q;
        if (tgt_q == TGT_W'(c))   bit_d = 1'b0;  // drop from old owner
        if (new_tgt == TGT_W'(c)) bit_d = 1'b1;  // add to new owner
      end
      always_ff @(posedge clk) begin
        if (!rst_n)     bit_q <= (c == 0);
        else if (wr_me) bit_q <= bit_d;
      end
      assign map_flat[c*NUM_SPI + s] = bit_q;
    end
  end

  assign rd_aff = aff_arr[rd_slot];
endmodule

// File: rtl/spi_affinity_router.sv
module spi_affinity_router
  import spi_route_pkg::*;
#(
  parameter int NUM_SPI = 8,
  parameter int NUM_CPU = 4,
  localparam int SLOT_W = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1,
  localparam int ADDR_W = SLOT_W + 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic [NUM_CPU*AFF_W-1:0]   cpu_aff_tab,
  output logic [NUM_CPU*NUM_SPI-1:0] cpu_spi_map,
  output logic [NUM_SPI*TGT_W-1:0]   spi_target
);
  // Named decode events
  logic [SLOT_W-1:0] acc_slot;
  logic              acc_upper;
  logic              acc_in_range;
  logic              wr_lo_hit;
  logic              rd_lo_hit;
  logic [31:0]       wr_packed;
  logic              lk_hit;
  logic [TGT_W-1:0]  lk_idx;
  logic [31:0]       slot_aff;
  logic [63:0]       slot_reg;

  assign acc_slot     = reg_addr[ADDR_W-1:3];
  assign acc_upper    = reg_addr[2];
  assign acc_in_range = (32'(acc_slot) < NUM_SPI);
  assign wr_lo_hit    = reg_wr && !acc_upper && acc_in_range;
  assign rd_lo_hit    = reg_rd && !acc_upper && acc_in_range;
  assign wr_packed    = pack_aff(reg_wdata);

  aff_lookup #(.NUM_CPU(NUM_CPU)) u_lookup (
    .aff (wr_packed[AFF_W-1:0]),
    .tab (cpu_aff_tab),
    .hit (lk_hit),
    .idx (lk_idx)
  );

  spi_route_store #(.NUM_SPI(NUM_SPI), .NUM_CPU(NUM_CPU)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_lo_hit),
    .wr_slot  (acc_slot),
    .wr_aff   (wr_packed),
    .new_tgt  (lk_hit ? lk_idx : TGT_NONE),
    .rst_aff  (cpu_aff_tab[AFF_W-1:0]),
    .rd_slot  (acc_slot),
    .rd_aff   (slot_aff),
    .tgt_flat (spi_target),
    .map_flat (cpu_spi_map)
  );

  assign slot_reg = unpack_aff(slot_aff);

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_lo_hit ? slot_reg[31:0] : 32'h0;
  end
endmodule

// File: rtl/spi_affinity_router_chk.sv
module spi_affinity_router_chk
  import spi_route_pkg::*;
#(
  parameter int NUM_SPI = 8,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_wr,
  input logic                       reg_rd,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [31:0]                reg_rdata,
  input logic [NUM_CPU*NUM_SPI-1:0] cpu_spi_map,
  input logic [NUM_SPI*TGT_W-1:0]   spi_target
);
  a_r2_upper_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[2]) |=> ($stable(spi_target) && $stable(cpu_spi_map)));

  a_r2_upper_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr[2]) |=> (reg_rdata == 32'h0));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(spi_target) && $stable(cpu_spi_map)));

  for (genvar s = 0; s < NUM_SPI; s++) begin : g_col
    logic [NUM_CPU-1:0] col;
    logic [TGT_W-1:0]   tgt;
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bit
      assign col[c] = cpu_spi_map[c*NUM_SPI + s];
    end
    assign tgt = spi_target[s*TGT_W +: TGT_W];

    a_r4_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));

    a_r4_owner_matches_target: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt != TGT_NONE) |-> (col == (NUM_CPU'(1) << tgt)));

    a_r5_unrouted_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt == TGT_NONE) |-> (col == '0));
  end
endmodule

bind spi_affinity_router spi_affinity_router_chk #(
  .NUM_SPI(NUM_SPI), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .cpu_spi_map(cpu_spi_map), .spi_target(spi_target)
);

// File: tb/spi_affinity_router_tb_top.sv
`timescale 1ns/1ps
module spi_affinity_router_tb_top;
  localparam int NS = 8;
  localparam int NC = 4;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NC*24-1:0] tab;
  logic [NC*NS-1:0] cpu_spi_map;
  logic [NS*8-1:0] spi_target;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_aff [NS];
  logic [7:0]  exp_tgt [NS];

  // CPU 3 duplicates CPU 1 to exercise R8
  assign tab = {24'h0A0B0C, 24'h102030, 24'h0A0B0C, 24'h010203};

  always #2.5 clk = ~clk;

  spi_affinity_router #(.NUM_SPI(NS), .NUM_CPU(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_aff_tab(tab), .cpu_spi_map(cpu_spi_map), .spi_target(spi_target)
  );

  function automatic logic [7:0] model_idx(input logic [23:0] a);
    for (int c = 0; c < NC; c++)
      if (tab[c*24 +: 24] == a) return 8'(c);
    return 8'hFF;
  endfunction

  function automatic logic [NS-1:0] model_map(input int c);
    logic [NS-1:0] m = '0;
    for (int s = 0; s < NS; s++) m[s] = (exp_tgt[s] == 8'(c));
    return m;
  endfunction

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input int s, input bit upper, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(s*8 + (upper ? 4 : 0)); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_word(input int s, input bit upper, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = AW'(s*8 + (upper ? 4 : 0));
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // R4 R5 R7: every target and bitmap against the model
  task automatic check_state(input string req);
    for (int s = 0; s < NS; s++)
      chk32({req, " target"}, 32'(spi_target[s*8 +: 8]), 32'(exp_tgt[s]));
    for (int c = 0; c < NC; c++)
      chk32({req, " bitmap"}, 32'(cpu_spi_map[c*NS +: NS]), 32'(model_map(c)));
  endtask

  task automatic do_write(input string req, input int s, input bit upper, input logic [31:0] d);
    logic [31:0] rb;
    wr_word(s, upper, d);
    if (!upper) begin
      exp_aff[s] = d[23:0];
      exp_tgt[s] = model_idx(d[23:0]);
    end
    check_state(req);
    rd_word(s, 1'b0, rb);
    chk32({req, " R3 readback"}, rb, {8'h00, exp_aff[s]});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] rb;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < NS; s++) begin
      exp_aff[s] = tab[23:0];
      exp_tgt[s] = 8'h00;
    end
    @(negedge clk);
    check_state("R6 reset");
    for (int s = 0; s < NS; s++) begin
      rd_word(s, 1'b0, rb);
      chk32("R6 reset affinity", rb, {8'h00, tab[23:0]});
      rd_word(s, 1'b1, rb);
      chk32("R2 upper reads zero", rb, 32'h0);
    end
    // directed corners
    do_write("R4 route to cpu2", 3, 1'b0, {8'h00, 24'h102030});
    do_write("R4 move cpu2 to cpu0", 3, 1'b0, {8'h00, 24'h010203});
    do_write("R8 duplicate picks cpu1", 5, 1'b0, {8'h00, 24'h0A0B0C});
    do_write("R5 unmatched", 5, 1'b0, {8'h00, 24'h777777});
    do_write("R5 rematch after unrouted", 5, 1'b0, {8'h00, 24'h102030});
    do_write("R1 top byte dropped", 6, 1'b0, 32'hAB102030);
    do_write("R2 upper write ignored", 6, 1'b1, 32'hFFFFFFFF);
    rd_word(6, 1'b1, rb);
    chk32("R2 upper still zero", rb, 32'h0);
    do_write("R1 last slot", NS-1, 1'b0, {8'h00, 24'h0A0B0C});
    // random mix
    for (int i = 0; i < 200; i++) begin
      int s;
      bit up;
      logic [31:0] d;
      s = int'($urandom % NS);
      up = ($urandom % 8) == 0;
      d = $urandom;
      if ($urandom % 2) d[23:0] = tab[($urandom % NC)*24 +: 24];
      do_write("R7 random", s, up, d);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule